// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor whose datapath shares one ALU, one memory port and one register file across several cycles per instruction. A four-bit state register walks each instruction through fetch, decode and then a short, instruction-specific chain of execute, memory and write-back states. Each state drives one fixed set of datapath enables and multiplexer selects. Decoding the state alone produces these outputs. The ALU zero flag only affects the effective PC load.

The next state comes from one of three sources. It can return to fetch, it can be a dispatch on the opcode (used only in decode), or it can be the current state plus one. Each instruction's states therefore lie at consecutive codes. The last state of every chain returns to fetch. Five instructions are supported: register-register ALU, OR-immediate, load word, store word and branch-if-equal. Any other opcode goes back to fetch straight from decode and writes nothing.

Top module: `mc_ctrl_seq`

## Requirements
- R1: A synchronous reset forces the fetch state. The fetch outputs appear in the cycle after any clock edge that sees reset high, hold for as long as reset stays high, and the sequence continues with decode after release.
- R2: Fetch asserts ir_wr, mem_rd and pc_wr with addr_sel=0 (PC) and pc_src=0 (ALU result). The ALU adds PC to 4: alu_a_sel=0 (PC), alu_b_sel=01 (constant 4), alu_op=00 (add). pc_ld is 1. Decode always follows fetch.
- R3: Decode writes nothing. It adds PC to the shifted sign-extended offset (alu_a_sel=0, alu_b_sel=11, ext_zero=0, alu_op=00) and dispatches on the opcode. The opcodes are 000000 for register-register, 001101 for OR-immediate, 100011 for load, 101011 for store and 000100 for branch.
- R4: Register-register takes two states after decode. The first sets alu_a_sel=1 (register A), alu_b_sel=00 (register B) and alu_op=11 (function field). The second asserts reg_wr with dst_sel=1 (rd) and wb_sel=0 (ALU output register).
- R5: OR-immediate takes two states after decode. The first sets alu_a_sel=1, alu_b_sel=10 (extended immediate), ext_zero=1 and alu_op=10 (OR). The second asserts reg_wr with dst_sel=0 (rt) and wb_sel=0.
- R6: Load takes three states after decode. The first computes the address (alu_a_sel=1, alu_b_sel=10, ext_zero=0, alu_op=00). The second asserts mem_rd with addr_sel=1 (ALU output register). The third asserts reg_wr with dst_sel=0 and wb_sel=1 (memory data).
- R7: Store takes two states after decode. The first computes the address as in load. The second asserts mem_wr with addr_sel=1.
- R8: Branch takes one state after decode. It sets alu_a_sel=1, alu_b_sel=00 and alu_op=01 (subtract), asserts pc_wr_cond and pc_src=1 (ALU output register), and drives pc_ld equal to alu_zero. The next state is fetch.
- R9: After decode, an unrecognised opcode returns to fetch. No reg_wr, mem_wr or PC load is asserted on the way.
- R10: The opcode is used only in decode. A change of opcode later in a chain does not change that chain.
- R11: alu_zero affects nothing except pc_ld in the branch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPW | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if alu_zero |
| pc_ld | output | 1 | Effective PC load enable |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| ir_wr | output | 1 | Instruction register write |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 ALU output register, 1 memory data |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 B, 01 four, 10 immediate, 11 immediate shifted |
| ext_zero | output | 1 | Immediate extension: 0 sign, 1 zero |
| alu_op | output | 2 | 00 add, 01 subtract, 10 OR, 11 function field |

## Verification
The assertions check every cycle that decode follows fetch and that the state code stays within the used range. They also check that each chain-ending state, including a branch, a write-back or an unrecognised dispatch, is followed by fetch, that no two of memory read, memory write and register write coincide, and that the opcode table has no duplicate entries. Only the bench's scenarios can show the exact selects of each state per instruction, the effect of the zero flag on a taken or untaken branch, that a late opcode change is ignored, and recovery from a reset in the middle of a chain.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
   localparam int ST_W = 4;
   typedef logic [ST_W-1:0] st_t;

   // consecutive codes per instruction chain: the increment kind relies on it
   localparam st_t S_FETCH   = 4'd0;
   localparam st_t S_DECODE  = 4'd1;
   localparam st_t S_R_EXE   = 4'd2;
   localparam st_t S_R_WB    = 4'd3;
   localparam st_t S_ORI_EXE = 4'd4;
   localparam st_t S_ORI_WB  = 4'd5;
   localparam st_t S_LW_ADR  = 4'd6;
   localparam st_t S_LW_MEM  = 4'd7;
   localparam st_t S_LW_WB   = 4'd8;
   localparam st_t S_SW_ADR  = 4'd9;
   localparam st_t S_SW_MEM  = 4'd10;
   localparam st_t S_BEQ     = 4'd11;
   localparam st_t S_LAST    = S_BEQ;

   typedef enum logic [1:0] {SQ_ZERO, SQ_DISP, SQ_INC} seq_e;

   localparam logic [1:0] AOP_ADD = 2'd0, AOP_SUB = 2'd1, AOP_OR = 2'd2, AOP_FN = 2'd3;
   localparam logic [1:0] BS_REG = 2'd0, BS_FOUR = 2'd1, BS_IMM = 2'd2, BS_IMM_SH = 2'd3;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       pc_src;
      logic       ir_wr;
      logic       mem_rd;
      logic       mem_wr;
      logic       addr_sel;
      logic       reg_wr;
      logic       dst_sel;
      logic       wb_sel;
      logic       alu_a_sel;
      logic [1:0] alu_b_sel;
      logic       ext_zero;
      logic [1:0] alu_op;
   } ctrl_t;

   localparam int NOPS = 5;
endpackage

// File: rtl/mcs_dispatch.sv
module mcs_dispatch
   import mcs_pkg::*;
#(
   parameter int OPW  = 6,
   parameter int NENT = NOPS
) (
   input  logic [OPW-1:0]       opcode,
   input  logic [NENT*OPW-1:0]  op_tab,
   input  logic [NENT*ST_W-1:0] tgt_tab,
   output logic [NENT-1:0]      match,
   output logic                 hit,
   output st_t                  target
);
   for (genvar i = 0; i < NENT; i++) begin : g_cmp
      assign match[i] = (opcode == op_tab[i*OPW +: OPW]);
   end

   assign hit = |match;

   always_comb begin
      target = S_FETCH;
      for (int i = 0; i < NENT; i++) begin
         if (match[i]) target = target | tgt_tab[i*ST_W +: ST_W];
      end
   end
endmodule

// File: rtl/mcs_ctrl_rom.sv
module mcs_ctrl_rom
   import mcs_pkg::*;
(
   input  st_t   state,
   output ctrl_t ctl,
   output seq_e  kind
);
   always_comb begin
      ctl  = '0;
      kind = SQ_ZERO;
      case (state)
         S_FETCH: begin
            ctl.pc_wr     = 1'b1;
            ctl.ir_wr     = 1'b1;
            ctl.mem_rd    = 1'b1;
            ctl.alu_b_sel = BS_FOUR;
            ctl.alu_op    = AOP_ADD;
            kind          = SQ_INC;
         end
         S_DECODE: begin
            ctl.alu_b_sel = BS_IMM_SH;
            ctl.alu_op    = AOP_ADD;
            kind          = SQ_DISP;
         end
         S_R_EXE: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = BS_REG;
            ctl.alu_op    = AOP_FN;
            kind          = SQ_INC;
         end
         S_R_WB: begin
            ctl.reg_wr  = 1'b1;
            ctl.dst_sel = 1'b1;
         end
         S_ORI_EXE: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = BS_IMM;
            ctl.ext_zero  = 1'b1;
            ctl.alu_op    = AOP_OR;
            kind          = SQ_INC;
         end
         S_ORI_WB: ctl.reg_wr = 1'b1;
         S_LW_ADR, S_SW_ADR: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = BS_IMM;
            ctl.alu_op    = AOP_ADD;
            kind          = SQ_INC;
         end
         S_LW_MEM: begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_sel = 1'b1;
            kind         = SQ_INC;
         end
         S_LW_WB: begin
            ctl.reg_wr = 1'b1;
            ctl.wb_sel = 1'b1;
         end
         S_SW_MEM: begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         S_BEQ: begin
            ctl.alu_a_sel  = 1'b1;
            ctl.alu_b_sel  = BS_REG;
            ctl.alu_op     = AOP_SUB;
            ctl.pc_wr_cond = 1'b1;
            ctl.pc_src     = 1'b1;
         end
         default: kind = SQ_ZERO;
      endcase
   end
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
   import mcs_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  seq_e kind,
   input  logic disp_hit,
   input  st_t  disp_tgt,
   output st_t  state
);
   st_t nxt;

   always_comb begin
      case (kind)
         SQ_DISP: nxt = disp_hit ? disp_tgt : S_FETCH;
         SQ_INC:  nxt = state + 4'd1;
         default: nxt = S_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= S_FETCH;
      else     state <= nxt;
   end

   // R2: decode always follows fetch
   p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
      state == S_FETCH |=> state == S_DECODE);

   // R3: the state code never leaves the used range
   p_state_range_r3: assert property (@(posedge clk) disable iff (rst)
      state <= S_LAST);

   // R9: a chain end or failed dispatch lands in fetch
   p_chain_end_r9: assert property (@(posedge clk) disable iff (rst)
      (kind == SQ_ZERO || (kind == SQ_DISP && !disp_hit)) |=> state == S_FETCH);
endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
   import mcs_pkg::*;
#(
   parameter int             OPW      = 6,
   parameter logic [OPW-1:0] OP_RTYPE = 6'b000000,
   parameter logic [OPW-1:0] OP_ORI   = 6'b001101,
   parameter logic [OPW-1:0] OP_LW    = 6'b100011,
   parameter logic [OPW-1:0] OP_SW    = 6'b101011,
   parameter logic [OPW-1:0] OP_BEQ   = 6'b000100
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [OPW-1:0] opcode,
   input  logic           alu_zero,
   output logic           pc_wr,
   output logic           pc_wr_cond,
   output logic           pc_ld,
   output logic           pc_src,
   output logic           ir_wr,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic           addr_sel,
   output logic           reg_wr,
   output logic           dst_sel,
   output logic           wb_sel,
   output logic           alu_a_sel,
   output logic [1:0]     alu_b_sel,
   output logic           ext_zero,
   output logic [1:0]     alu_op
);
   localparam logic [NOPS*OPW-1:0]  OP_TAB  = {OP_BEQ, OP_SW, OP_LW, OP_ORI, OP_RTYPE};
   localparam logic [NOPS*ST_W-1:0] TGT_TAB = {S_BEQ, S_SW_ADR, S_LW_ADR, S_ORI_EXE, S_R_EXE};

   if (OPW < 3) begin : g_bad_opw
      $error("mc_ctrl_seq: OPW too small to hold five distinct opcodes");
   end
   for (genvar i = 0; i < NOPS; i++) begin : g_chk_i
      for (genvar j = i + 1; j < NOPS; j++) begin : g_chk_j
         if (OP_TAB[i*OPW +: OPW] == OP_TAB[j*OPW +: OPW]) begin : g_dup
            $error("mc_ctrl_seq: two opcode parameters share one value");
         end
      end
   end

   st_t             cur_st;
   ctrl_t           ctl;
   seq_e            kind;
   logic            disp_hit;
   st_t             disp_tgt;
   logic [NOPS-1:0] disp_match;

   mcs_dispatch #(.OPW(OPW), .NENT(NOPS)) u_disp (
      .opcode (opcode),
      .op_tab (OP_TAB),
      .tgt_tab(TGT_TAB),
      .match  (disp_match),
      .hit    (disp_hit),
      .target (disp_tgt)
   );

   mcs_ctrl_rom u_rom (
      .state(cur_st),
      .ctl  (ctl),
      .kind (kind)
   );

   mcs_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .kind    (kind),
      .disp_hit(disp_hit),
      .disp_tgt(disp_tgt),
      .state   (cur_st)
   );

   assign pc_wr      = ctl.pc_wr;
   assign pc_wr_cond = ctl.pc_wr_cond;
   assign pc_ld      = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);
   assign pc_src     = ctl.pc_src;
   assign ir_wr      = ctl.ir_wr;
   assign mem_rd     = ctl.mem_rd;
   assign mem_wr     = ctl.mem_wr;
   assign addr_sel   = ctl.addr_sel;
   assign reg_wr     = ctl.reg_wr;
   assign dst_sel    = ctl.dst_sel;
   assign wb_sel     = ctl.wb_sel;
   assign alu_a_sel  = ctl.alu_a_sel;
   assign alu_b_sel  = ctl.alu_b_sel;
   assign ext_zero   = ctl.ext_zero;
   assign alu_op     = ctl.alu_op;

   // R3: one opcode selects at most one chain
   p_unique_op_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(disp_match));

   // R6: memory read, memory write and register write never coincide
   p_one_access_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0({mem_rd, mem_wr, reg_wr}));

   // R8: a branch state is followed by a fetch
   p_branch_ends_r8: assert property (@(posedge clk) disable iff (rst)
      pc_wr_cond |=> ir_wr);

   // R4: every register write-back ends its chain
   p_wb_ends_r4: assert property (@(posedge clk) disable iff (rst)
      reg_wr |=> ir_wr);

   // R9: an unknown opcode in decode goes straight back to fetch
   p_illegal_r9: assert property (@(posedge clk) disable iff (rst)
      (cur_st == S_DECODE && !disp_hit) |=> ir_wr);
endmodule

// File: tb/sim_mc_ctrl_seq.sv
`timescale 1ns/1ps
module sim_mc_ctrl_seq;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'd0;
   logic       alu_zero = 1'b0;
   logic       pc_wr, pc_wr_cond, pc_ld, pc_src, ir_wr, mem_rd, mem_wr, addr_sel;
   logic       reg_wr, dst_sel, wb_sel, alu_a_sel, ext_zero;
   logic [1:0] alu_b_sel, alu_op;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   mc_ctrl_seq u0 (
      .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_ld(pc_ld), .pc_src(pc_src),
      .ir_wr(ir_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
      .reg_wr(reg_wr), .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
      .alu_b_sel(alu_b_sel), .ext_zero(ext_zero), .alu_op(alu_op)
   );

   logic [16:0] act;
   assign act = {pc_wr, pc_wr_cond, pc_ld, pc_src, ir_wr, mem_rd, mem_wr, addr_sel,
                 reg_wr, dst_sel, wb_sel, alu_a_sel, alu_b_sel, ext_zero, alu_op};

   // fields: pcw cond ld src ir rd wr addr reg dst wb a b ez op
   localparam logic [16:0] W_FETCH = 17'b1_0_1_0_1_1_0_0_0_0_0_0_01_0_00;
   localparam logic [16:0] W_DEC   = 17'b0_0_0_0_0_0_0_0_0_0_0_0_11_0_00;
   localparam logic [16:0] W_REX   = 17'b0_0_0_0_0_0_0_0_0_0_0_1_00_0_11;
   localparam logic [16:0] W_RWB   = 17'b0_0_0_0_0_0_0_0_1_1_0_0_00_0_00;
   localparam logic [16:0] W_OEX   = 17'b0_0_0_0_0_0_0_0_0_0_0_1_10_1_10;
   localparam logic [16:0] W_OWB   = 17'b0_0_0_0_0_0_0_0_1_0_0_0_00_0_00;
   localparam logic [16:0] W_ADR   = 17'b0_0_0_0_0_0_0_0_0_0_0_1_10_0_00;
   localparam logic [16:0] W_LMEM  = 17'b0_0_0_0_0_1_0_1_0_0_0_0_00_0_00;
   localparam logic [16:0] W_LWB   = 17'b0_0_0_0_0_0_0_0_1_0_1_0_00_0_00;
   localparam logic [16:0] W_SMEM  = 17'b0_0_0_0_0_0_1_1_0_0_0_0_00_0_00;
   localparam logic [16:0] W_BQ0   = 17'b0_1_0_1_0_0_0_0_0_0_0_1_00_0_01;
   localparam logic [16:0] W_BQ1   = 17'b0_1_1_1_0_0_0_0_0_0_0_1_00_0_01;

   localparam logic [5:0] O_R = 6'b000000, O_ORI = 6'b001101, O_LW = 6'b100011;
   localparam logic [5:0] O_SW = 6'b101011, O_BEQ = 6'b000100, O_BAD = 6'b111111;

   // row: {requirement number, opcode, alu_zero, expected outputs}
   localparam int NV = 29;
   localparam logic [27:0] VEC [NV] = '{
      {4'd2,  O_R,   1'b0, W_FETCH}, {4'd3,  O_R,   1'b0, W_DEC},    // R2 R3
      {4'd4,  O_R,   1'b0, W_REX},   {4'd4,  O_R,   1'b0, W_RWB},    // R4
      {4'd2,  O_ORI, 1'b0, W_FETCH}, {4'd3,  O_ORI, 1'b0, W_DEC},
      {4'd5,  O_ORI, 1'b0, W_OEX},   {4'd5,  O_ORI, 1'b0, W_OWB},    // R5
      {4'd2,  O_LW,  1'b0, W_FETCH}, {4'd3,  O_LW,  1'b0, W_DEC},
      {4'd6,  O_LW,  1'b0, W_ADR},   {4'd6,  O_LW,  1'b0, W_LMEM},   // R6
      {4'd6,  O_LW,  1'b0, W_LWB},
      {4'd2,  O_SW,  1'b0, W_FETCH}, {4'd3,  O_SW,  1'b0, W_DEC},
      {4'd7,  O_SW,  1'b0, W_ADR},   {4'd7,  O_SW,  1'b0, W_SMEM},   // R7
      {4'd2,  O_BEQ, 1'b0, W_FETCH}, {4'd3,  O_BEQ, 1'b0, W_DEC},
      {4'd8,  O_BEQ, 1'b0, W_BQ0},                                   // R8 not taken
      {4'd11, O_BEQ, 1'b1, W_FETCH}, {4'd11, O_BEQ, 1'b1, W_DEC},    // R11
      {4'd8,  O_BEQ, 1'b1, W_BQ1},                                   // R8 taken
      {4'd2,  O_BAD, 1'b0, W_FETCH}, {4'd9,  O_BAD, 1'b0, W_DEC},    // R9
      {4'd9,  O_R,   1'b1, W_FETCH}, {4'd11, O_R,   1'b1, W_DEC},    // R9 back to fetch
      {4'd11, O_R,   1'b1, W_REX},   {4'd11, O_R,   1'b1, W_RWB}
   };

   task automatic chk(input int tag, input logic [16:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input logic [5:0] op, input logic z, input int tag, input logic [16:0] exp);
      opcode   = op;
      alu_zero = z;
      #1 chk(tag, exp);
      @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset held over several edges shows fetch
      repeat (2) @(negedge clk);
      #1 chk(1, W_FETCH);
      @(negedge clk);
      #1 chk(1, W_FETCH);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][23:18], VEC[i][17], int'(VEC[i][27:24]), VEC[i][16:0]);
      end

      // R10: opcode changed after dispatch does not alter the load chain
      step(O_LW, 1'b0, 10, W_FETCH);
      step(O_LW, 1'b0, 10, W_DEC);
      step(O_SW, 1'b0, 10, W_ADR);
      step(O_SW, 1'b0, 10, W_LMEM);
      step(O_ORI, 1'b0, 10, W_LWB);

      // R1: reset in the middle of a chain returns to fetch, then resumes
      step(O_LW, 1'b0, 1, W_FETCH);
      step(O_LW, 1'b0, 1, W_DEC);
      step(O_LW, 1'b0, 1, W_ADR);
      rst = 1'b1;
      @(negedge clk);
      #1 chk(1, W_FETCH);
      rst = 1'b0;
      @(negedge clk);
      #1 chk(1, W_DEC);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule